// File: doc/BRIEF.md
# SMBus Host Register File and Transaction Launcher

This block sits between a byte-wide I/O register bus and the bus engine of an SMBus master. Software programs the target address, command byte and data bytes, then writes the control register with the start bit set. The block hands the protocol type, PEC request and programmed bytes to the engine, raises a one-cycle start request and holds a busy flag until the engine answers.

The engine replies with a done pulse and, in the same cycle, flags for no-acknowledge, lost arbitration or failure. The block turns these into sticky status flags, which software clears by writing ones to them. A kill bit in the control register aborts a running transfer. On a successful read, the engine's result bytes are captured into the data registers. Register reads are combinational. A two-flop synchronizer releases the internal reset.

Top module: `smb_host_regs`

## Requirements
- R1: After reset every register offset from 0 to 15 reads 0x00, and eng_start, eng_abort, eng_crc_en and eng_buf32 are low.
- R2: Offsets 3 (command), 4 (address: target in bits 7:1, read/not-write in bit 0), 5 (data0) and 6 (data1) read back the last byte written to them. Offsets 1, 7 to 12, 14 and 15 read 0x00 and ignore writes.
- R3: A write to offset 2 with bit 6 set, made while idle, launches a transfer. In the next cycle eng_start pulses for one cycle and status bit 0 (busy) is set. eng_proto carries control bits 4:2 (0 quick, 1 byte, 2 byte-data, 3 word, 4 process call, 5 block, 6 I2C block) and eng_pec carries bit 7. The control register reads back the written byte with bit 6 cleared.
- R4: While busy, a control write produces no eng_start and changes only the kill bit (bit 1) of the control register.
- R5: An eng_done pulse while busy clears busy in the next cycle and sets status bit 1. Bit 2 is also set on eng_nak, bit 3 on eng_arb_lost and bit 4 on eng_fail. An eng_done pulse while idle changes nothing.
- R6: Writing offset 0 clears each of status bits 7, 4, 3, 2 and 1 whose written bit is 1 and leaves the others unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R7: While control bit 1 (kill) is 1 and busy is set, eng_abort is high. In the next cycle busy clears and status bit 4 (failed) is set, but status bit 1 is not.
- R8: On an error-free completion with address bit 0 = 1, a byte or byte-data transfer loads data0 from eng_rdat0, and a word transfer loads data0 from eng_rdat0 (low byte) and data1 from eng_rdat1 (high byte). Write transfers and errored completions leave data0 and data1 unchanged.
- R9: Offset 13 holds two bits that read back as written. Bit 0 drives eng_crc_en and bit 1 drives eng_buf32. Bits 7:2 read 0.
- R10: An eng_byte_done pulse sets status bit 7. Status bit 5 follows the smb_alert input level, and status bit 6 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| eng_start | output | 1 | One-cycle launch request |
| eng_abort | output | 1 | Abort request while kill is set and busy |
| eng_proto | output | 3 | Protocol type |
| eng_pec | output | 1 | PEC requested for this transfer |
| eng_crc_en | output | 1 | Hardware CRC enable |
| eng_buf32 | output | 1 | 32-byte buffer mode enable |
| eng_target | output | 8 | Address register (target and direction) |
| eng_cmd | output | 8 | Command byte |
| eng_wdat0 | output | 8 | Data0 register |
| eng_wdat1 | output | 8 | Data1 register |
| eng_done | input | 1 | Transfer finished pulse |
| eng_nak | input | 1 | No response, valid with eng_done |
| eng_arb_lost | input | 1 | Lost arbitration, valid with eng_done |
| eng_fail | input | 1 | Transfer failed, valid with eng_done |
| eng_byte_done | input | 1 | Per-byte completion pulse |
| eng_rdat0 | input | 8 | Read result low byte |
| eng_rdat1 | input | 8 | Read result high byte |
| smb_alert | input | 1 | Alert level |

## Verification
Two situations are hard to reach from the ports: a control write that lands while a transfer is already running, and a status clear that lands in the same cycle the engine sets that flag. The stimulus launches a transfer and holds off the engine's done pulse, which keeps busy high. It then issues a second start write and a kill write while busy. In a separate case it drives the done pulse and a clear of the interrupt flag on the same clock edge, to show that the set wins. Error completions are checked against the data registers to confirm that no result is loaded.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;
  localparam int unsigned OFF_STS = 0;
  localparam int unsigned OFF_CTL = 2;
  localparam int unsigned OFF_CMD = 3;
  localparam int unsigned OFF_ADR = 4;
  localparam int unsigned OFF_D0  = 5;
  localparam int unsigned OFF_D1  = 6;
  localparam int unsigned OFF_AUX = 13;

  localparam int unsigned ST_BUSY  = 0;
  localparam int unsigned ST_INTR  = 1;
  localparam int unsigned ST_DERR  = 2;
  localparam int unsigned ST_BERR  = 3;
  localparam int unsigned ST_FAIL  = 4;
  localparam int unsigned ST_ALRT  = 5;
  localparam int unsigned ST_BDONE = 7;

  localparam int unsigned CT_KILL  = 1;
  localparam int unsigned CT_PLO   = 2;
  localparam int unsigned CT_START = 6;
  localparam int unsigned CT_PEC   = 7;

  localparam logic [7:0] W1C_MASK = 8'h9E;

  typedef enum logic [2:0] {
    PR_QUICK  = 3'd0,
    PR_BYTE   = 3'd1,
    PR_BDATA  = 3'd2,
    PR_WORD   = 3'd3,
    PR_PCALL  = 3'd4,
    PR_BLOCK  = 3'd5,
    PR_I2CBLK = 3'd6,
    PR_RSVD   = 3'd7
  } proto_e;
endpackage

// File: rtl/smb_hreg_launch.sv
module smb_hreg_launch
  import smb_host_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic          aux_we,
  input  logic [DW-1:0] wdata,
  input  logic          busy_i,
  output logic [DW-1:0] ctl_q,
  output logic [1:0]    aux_q,
  output logic          go_o,
  output logic          start_o,
  output logic          abort_o,
  output logic [2:0]    proto_o,
  output logic          pec_o
);
  localparam logic [DW-1:0] START_M = DW'(1) << CT_START;
  localparam logic [DW-1:0] KILL_M  = DW'(1) << CT_KILL;

  logic [DW-1:0] ctl_d;
  logic [1:0]    aux_d;
  logic          start_d;

  always_comb begin
    go_o    = ctl_we && wdata[CT_START] && !busy_i;
    start_d = go_o;
    ctl_d   = ctl_q;
    if (ctl_we) begin
      if (busy_i) ctl_d[CT_KILL] = wdata[CT_KILL];
      else        ctl_d = wdata & ~START_M;
    end
    aux_d = aux_we ? wdata[1:0] : aux_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      aux_q   <= '0;
      start_q <= 1'b0;
    end else begin
      ctl_q   <= ctl_d;
      aux_q   <= aux_d;
      start_q <= start_d;
    end
  end

  logic start_q;
  assign start_o = start_q;
  assign abort_o = ctl_q[CT_KILL] && busy_i;
  assign proto_o = ctl_q[CT_PLO +: 3];
  assign pec_o   = ctl_q[CT_PEC];

  assert_start_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(ctl_we && wdata[CT_START]));
  assert_no_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i && ctl_we |=> !start_o);
  assert_busy_ctl_kill_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i && ctl_we |=> (ctl_q & ~KILL_M) == $past(ctl_q & ~KILL_M));
  assert_aux_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    aux_we |=> aux_q == $past(wdata[1:0]));
endmodule

// File: rtl/smb_hreg_status.sv
module smb_hreg_status
  import smb_host_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic          abort_i,
  input  logic          done_i,
  input  logic          nak_i,
  input  logic          arb_i,
  input  logic          fail_i,
  input  logic          bdone_i,
  input  logic          alert_i,
  input  logic          w1c_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] sts_o,
  output logic          busy_o
);
  logic [DW-1:0] flags_q, flags_d;
  logic          busy_q, busy_d;
  logic          fin;

  always_comb begin
    fin    = busy_q && done_i;
    busy_d = busy_q;
    if (go_i) busy_d = 1'b1;
    if (fin || abort_i) busy_d = 1'b0;

    flags_d = flags_q;
    if (w1c_we) flags_d = flags_q & ~(wdata & DW'(W1C_MASK));
    if (fin) begin
      flags_d[ST_INTR] = 1'b1;
      if (nak_i)  flags_d[ST_DERR] = 1'b1;
      if (arb_i)  flags_d[ST_BERR] = 1'b1;
      if (fail_i) flags_d[ST_FAIL] = 1'b1;
    end
    if (abort_i) flags_d[ST_FAIL]  = 1'b1;
    if (bdone_i) flags_d[ST_BDONE] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      busy_q  <= 1'b0;
    end else begin
      flags_q <= flags_d;
      busy_q  <= busy_d;
    end
  end

  always_comb begin
    sts_o          = flags_q;
    sts_o[ST_BUSY] = busy_q;
    sts_o[ST_ALRT] = alert_i;
  end
  assign busy_o = busy_q;

  assert_busy_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(go_i));
  assert_done_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && done_i |=> !busy_q && flags_q[ST_INTR]);
  assert_idle_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && done_i && !go_i && !w1c_we && !bdone_i |=> $stable(flags_q));
  assert_kill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !busy_q && flags_q[ST_FAIL]);
  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    w1c_we && wdata[ST_INTR] && !done_i |=> !flags_q[ST_INTR]);
endmodule

// File: rtl/smb_hreg_data.sv
module smb_hreg_data
  import smb_host_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic          adr_we,
  input  logic          d0_we,
  input  logic          d1_we,
  input  logic [DW-1:0] wdata,
  input  logic          busy_i,
  input  logic          abort_i,
  input  logic          done_i,
  input  logic          err_i,
  input  logic [2:0]    proto_i,
  input  logic [DW-1:0] rdat0,
  input  logic [DW-1:0] rdat1,
  output logic [DW-1:0] cmd_q,
  output logic [DW-1:0] adr_q,
  output logic [DW-1:0] d0_q,
  output logic [DW-1:0] d1_q
);
  logic          ok_rd, ld0, ld1;
  logic [DW-1:0] cmd_d, adr_d, d0_d, d1_d;

  always_comb begin
    ok_rd = busy_i && done_i && !err_i && !abort_i && adr_q[0];
    ld0   = ok_rd && (proto_i == PR_BYTE || proto_i == PR_BDATA || proto_i == PR_WORD);
    ld1   = ok_rd && (proto_i == PR_WORD);
    cmd_d = cmd_we ? wdata : cmd_q;
    adr_d = adr_we ? wdata : adr_q;
    d0_d  = ld0 ? rdat0 : (d0_we ? wdata : d0_q);
    d1_d  = ld1 ? rdat1 : (d1_we ? wdata : d1_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      adr_q <= '0;
      d0_q  <= '0;
      d1_q  <= '0;
    end else begin
      cmd_q <= cmd_d;
      adr_q <= adr_d;
      d0_q  <= d0_d;
      d1_q  <= d1_d;
    end
  end

  assert_wr_xfer_keeps_d0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_i && !adr_q[0] && !d0_we |=> $stable(d0_q));
  assert_err_keeps_d1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_i && err_i && !d1_we |=> $stable(d1_q));
  assert_adr_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adr_we |=> adr_q == $past(wdata));
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_host_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          eng_start,
  output logic          eng_abort,
  output logic [2:0]    eng_proto,
  output logic          eng_pec,
  output logic          eng_crc_en,
  output logic          eng_buf32,
  output logic [DW-1:0] eng_target,
  output logic [DW-1:0] eng_cmd,
  output logic [DW-1:0] eng_wdat0,
  output logic [DW-1:0] eng_wdat1,
  input  logic          eng_done,
  input  logic          eng_nak,
  input  logic          eng_arb_lost,
  input  logic          eng_fail,
  input  logic          eng_byte_done,
  input  logic [DW-1:0] eng_rdat0,
  input  logic [DW-1:0] eng_rdat1,
  input  logic          smb_alert
);
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  logic sts_we, ctl_we, cmd_we, adr_we, d0_we, d1_we, aux_we;
  always_comb begin
    sts_we = reg_wr && (reg_addr == AW'(OFF_STS));
    ctl_we = reg_wr && (reg_addr == AW'(OFF_CTL));
    cmd_we = reg_wr && (reg_addr == AW'(OFF_CMD));
    adr_we = reg_wr && (reg_addr == AW'(OFF_ADR));
    d0_we  = reg_wr && (reg_addr == AW'(OFF_D0));
    d1_we  = reg_wr && (reg_addr == AW'(OFF_D1));
    aux_we = reg_wr && (reg_addr == AW'(OFF_AUX));
  end

  logic [DW-1:0] ctl_q, sts;
  logic [1:0]    aux_q;
  logic          go, busy;

  smb_hreg_launch #(.DW(DW)) u_launch (
    .clk(clk), .rst_n(rst_int_n), .ctl_we(ctl_we), .aux_we(aux_we),
    .wdata(reg_wdata), .busy_i(busy), .ctl_q(ctl_q), .aux_q(aux_q),
    .go_o(go), .start_o(eng_start), .abort_o(eng_abort),
    .proto_o(eng_proto), .pec_o(eng_pec)
  );

  smb_hreg_status #(.DW(DW)) u_status (
    .clk(clk), .rst_n(rst_int_n), .go_i(go), .abort_i(eng_abort),
    .done_i(eng_done), .nak_i(eng_nak), .arb_i(eng_arb_lost),
    .fail_i(eng_fail), .bdone_i(eng_byte_done), .alert_i(smb_alert),
    .w1c_we(sts_we), .wdata(reg_wdata), .sts_o(sts), .busy_o(busy)
  );

  smb_hreg_data #(.DW(DW)) u_data (
    .clk(clk), .rst_n(rst_int_n), .cmd_we(cmd_we), .adr_we(adr_we),
    .d0_we(d0_we), .d1_we(d1_we), .wdata(reg_wdata), .busy_i(busy),
    .abort_i(eng_abort), .done_i(eng_done),
    .err_i(eng_nak || eng_arb_lost || eng_fail), .proto_i(eng_proto),
    .rdat0(eng_rdat0), .rdat1(eng_rdat1), .cmd_q(eng_cmd),
    .adr_q(eng_target), .d0_q(eng_wdat0), .d1_q(eng_wdat1)
  );

  assign eng_crc_en = aux_q[0];
  assign eng_buf32  = aux_q[1];

  always_comb begin
    case (reg_addr)
      AW'(OFF_STS): reg_rdata = sts;
      AW'(OFF_CTL): reg_rdata = ctl_q;
      AW'(OFF_CMD): reg_rdata = eng_cmd;
      AW'(OFF_ADR): reg_rdata = eng_target;
      AW'(OFF_D0):  reg_rdata = eng_wdat0;
      AW'(OFF_D1):  reg_rdata = eng_wdat1;
      AW'(OFF_AUX): reg_rdata = {{(DW-2){1'b0}}, aux_q};
      default:      reg_rdata = '0;
    endcase
  end

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    eng_start |-> sts[ST_BUSY]);
  assert_abort_only_busy_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    eng_abort |-> sts[ST_BUSY]);
endmodule

// File: tb/smb_host_regs_tb.sv
`timescale 1ns/1ps
module smb_host_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       eng_start, eng_abort, eng_pec, eng_crc_en, eng_buf32;
  logic [2:0] eng_proto;
  logic [7:0] eng_target, eng_cmd, eng_wdat0, eng_wdat1;
  logic       eng_done, eng_nak, eng_arb_lost, eng_fail, eng_byte_done, smb_alert;
  logic [7:0] eng_rdat0, eng_rdat1;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  smb_host_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
    .eng_abort(eng_abort), .eng_proto(eng_proto), .eng_pec(eng_pec),
    .eng_crc_en(eng_crc_en), .eng_buf32(eng_buf32), .eng_target(eng_target),
    .eng_cmd(eng_cmd), .eng_wdat0(eng_wdat0), .eng_wdat1(eng_wdat1),
    .eng_done(eng_done), .eng_nak(eng_nak), .eng_arb_lost(eng_arb_lost),
    .eng_fail(eng_fail), .eng_byte_done(eng_byte_done), .eng_rdat0(eng_rdat0),
    .eng_rdat1(eng_rdat1), .smb_alert(smb_alert)
  );

  // {offset, write value, expected readback}
  localparam logic [23:0] VEC [10] = '{
    {8'd3,  8'hA5, 8'hA5}, {8'd4,  8'h6F, 8'h6F}, {8'd5,  8'h3C, 8'h3C},
    {8'd6,  8'hC3, 8'hC3}, {8'd13, 8'hFF, 8'h03}, {8'd13, 8'h02, 8'h02},
    {8'd7,  8'h55, 8'h00}, {8'd1,  8'h77, 8'h00}, {8'd8,  8'h11, 8'h00},
    {8'd14, 8'h22, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] off, input logic [7:0] d);
    @(negedge clk);
    reg_addr = off; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] off, output logic [7:0] v);
    reg_addr = off;
    #1;
    v = reg_rdata;
  endtask

  task automatic done_pulse(input logic nak, input logic arb, input logic fl,
                            input logic [7:0] r0, input logic [7:0] r1);
    @(negedge clk);
    eng_done = 1'b1; eng_nak = nak; eng_arb_lost = arb; eng_fail = fl;
    eng_rdat0 = r0; eng_rdat1 = r1;
    @(negedge clk);
    eng_done = 1'b0; eng_nak = 1'b0; eng_arb_lost = 1'b0; eng_fail = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    eng_done = 0; eng_nak = 0; eng_arb_lost = 0; eng_fail = 0;
    eng_byte_done = 0; smb_alert = 0; eng_rdat0 = '0; eng_rdat1 = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int i = 0; i < 16; i++) begin
      rd(4'(i), v);
      chk("R1 reset readback", v, 8'h00);
    end
    chk("R1 start/abort low", {eng_start, eng_abort, eng_crc_en, eng_buf32}, 4'h0);

    // R2 / R9: register table
    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][19:16], VEC[i][15:8]);
      rd(VEC[i][19:16], v);
      chk("R2/R9 table readback", v, VEC[i][7:0]);
    end
    chk("R9 aux pins", {eng_buf32, eng_crc_en}, 2'b10);

    // R3: launch byte-data read, PEC requested (address 0x6F is a read)
    wr(4'd2, 8'hC8);
    chk("R3 start pulse", eng_start, 1'b1);
    chk("R3 proto", eng_proto, 3'd2);
    chk("R3 pec", eng_pec, 1'b1);
    rd(4'd0, v); chk("R3 busy", v, 8'h01);
    rd(4'd2, v); chk("R3 ctl readback", v, 8'h88);
    @(negedge clk);
    chk("R3 pulse one cycle", eng_start, 1'b0);

    // R4: start while busy ignored
    wr(4'd2, 8'h4C);
    chk("R4 no start", eng_start, 1'b0);
    rd(4'd2, v); chk("R4 ctl unchanged", v, 8'h88);

    // R5 / R8: byte-data completion
    done_pulse(0, 0, 0, 8'h5A, 8'h99);
    rd(4'd0, v); chk("R5 intr set busy clear", v, 8'h02);
    rd(4'd5, v); chk("R8 data0 byte-data load", v, 8'h5A);
    rd(4'd6, v); chk("R8 data1 untouched", v, 8'hC3);

    // R6: zero write keeps, one clears
    wr(4'd0, 8'h00); rd(4'd0, v); chk("R6 zero write keeps", v, 8'h02);
    wr(4'd0, 8'h02); rd(4'd0, v); chk("R6 one clears", v, 8'h00);

    // R8: word read
    wr(4'd2, 8'h4C);
    chk("R3 word proto", eng_proto, 3'd3);
    done_pulse(0, 0, 0, 8'h34, 8'h12);
    rd(4'd5, v); chk("R8 word low", v, 8'h34);
    rd(4'd6, v); chk("R8 word high", v, 8'h12);
    wr(4'd0, 8'h02);

    // R5 / R8: errored write transfer
    wr(4'd4, 8'h6E);
    wr(4'd2, 8'h48);
    done_pulse(1, 1, 0, 8'hEE, 8'hEE);
    rd(4'd0, v); chk("R5 error flags", v, 8'h0E);
    rd(4'd5, v); chk("R8 no load on error", v, 8'h34);
    wr(4'd0, 8'h04); rd(4'd0, v); chk("R6 partial clear", v, 8'h0A);
    wr(4'd0, 8'h0A); rd(4'd0, v); chk("R6 full clear", v, 8'h00);

    // R5: done while idle ignored
    done_pulse(0, 0, 1, 8'h00, 8'h00);
    rd(4'd0, v); chk("R5 idle done ignored", v, 8'h00);

    // R7: kill
    wr(4'd2, 8'h48);
    wr(4'd2, 8'h02);
    chk("R7 abort high", eng_abort, 1'b1);
    rd(4'd0, v); chk("R7 still busy", v, 8'h01);
    @(negedge clk);
    rd(4'd0, v); chk("R7 failed not intr", v, 8'h10);
    chk("R7 abort drops", eng_abort, 1'b0);
    rd(4'd2, v); chk("R4 kill bit only", v, 8'h0A);
    wr(4'd2, 8'h00);
    wr(4'd0, 8'h10);

    // R6: set wins over clear in same cycle
    wr(4'd2, 8'h48);
    @(negedge clk);
    reg_addr = 4'd0; reg_wdata = 8'h02; reg_wr = 1'b1; eng_done = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; eng_done = 1'b0;
    rd(4'd0, v); chk("R6 set wins", v, 8'h02);
    wr(4'd0, 8'h02);

    // R10: byte done and alert
    @(negedge clk); eng_byte_done = 1'b1;
    @(negedge clk); eng_byte_done = 1'b0; smb_alert = 1'b1;
    rd(4'd0, v); chk("R10 bdone+alert", v, 8'hA0);
    wr(4'd0, 8'hE0); rd(4'd0, v); chk("R10 alert not cleared", v, 8'h20);
    smb_alert = 1'b0;
    rd(4'd0, v); chk("R10 alert follows", v, 8'h00);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule